// File: doc/BRIEF.md
# Prioritized External Interrupt Controller

This block collects five external interrupt request lines and decides which one the processor should take next. Every line has its own small control word that picks edge or level triggering, blocks or allows the line, and gives it a three-bit priority where a smaller number is more urgent. Inputs pass through a two-flop synchronizer. In edge mode a rising edge sets a sticky request. In level mode the request simply follows the synchronized input.

The controller raises `int_req` whenever some allowed request is pending and is more urgent than everything currently being serviced. When the processor pulses `inta`, the block latches the winner's vector type on `vec_out`, clears that source's sticky edge request and marks the source as in service. A write to the end-of-interrupt address retires the most urgent source that is in service. Control words are written and read through a small register port.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset every control word reads 000Fh (edge mode, masked, priority 7), `int_req` is low and `vec_out` is 00h.
- R2: Control words for int0..int4 sit at addresses 0..4. Bit 4 is the trigger mode (1 = level), bit 3 is the mask (1 = blocked) and bits 2:0 are the priority. Bits 15:5 read as zero and writes to them are ignored. Address 5 is the end-of-interrupt address and reads as zero, as do addresses 6 and 7.
- R3: A masked source never raises `int_req`. A rising edge that arrives while the source is masked stays latched and is presented once the mask is cleared. Masking a pending source withdraws its request.
- R4: In edge mode, `int_req` rises on the third clock edge after the input rises, and it stays high after the input falls until the request is acknowledged.
- R5: In level mode, the request follows the input with a two-clock delay. If the input falls before acknowledge, no request remains.
- R6: Among eligible requests the lowest priority value wins. On equal values the lower-numbered source wins.
- R7: The vector types are 0Ch, 0Dh, 0Eh, 0Fh and 11h for int0..int4. `vec_out` takes the winner's vector on the clock edge where `inta` is high while `int_req` is high, and it holds its value otherwise.
- R8: An acknowledge clears the winner's edge latch and sets its in-service bit. No in-service bit is set without an acknowledge.
- R9: While any source is in service, only requests whose priority value is strictly lower than the lowest in-service value are eligible.
- R10: A write to address 5 clears the in-service bit that has the lowest priority value, with ties going to the lower source number. The write data is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 5 | Asynchronous request lines int0..int4 |
| inta | input | 1 | Acknowledge pulse from the processor side |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| int_req | output | 1 | An eligible request exists |
| vec_out | output | 8 | Vector type of the last acknowledged request |

## Verification
The assertions assume that `inta` is a single-cycle pulse and that the end-of-interrupt write is a one-cycle strobe. They also assume that a source in level mode keeps its input high until it has been acknowledged whenever the test expects that acknowledge to succeed. The stimulus drives every input half a cycle away from the sampling edge and holds each request line for at least two clocks, so the synchronizer always captures it. Every acknowledge and end-of-interrupt is issued as exactly one-cycle pulses, and the reference model tracks in-service state, so retirement always targets a real in-service entry.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    parameter int NUM_SRC = 5;
    parameter int PRIO_W  = 3;
    parameter int DATA_W  = 16;
    parameter int VEC_W   = 8;
    parameter int SYNC_STAGES = 2;

    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int ADDR_W   = $clog2(NUM_SRC + 1);
    localparam int CTRL_W   = PRIO_W + 2;
    localparam int EOI_ADDR = NUM_SRC;

    typedef struct packed {
        logic              lvl;
        logic              mask;
        logic [PRIO_W-1:0] prio;
    } src_ctrl_t;

    localparam src_ctrl_t CTRL_RST = '{lvl: 1'b0, mask: 1'b1, prio: {PRIO_W{1'b1}}};

    function automatic logic [VEC_W-1:0] src_vector(input logic [IDX_W-1:0] idx);
        if (idx < IDX_W'(4))
            return VEC_W'(8'h0C) + VEC_W'(idx);
        else
            return VEC_W'(8'h11) + VEC_W'(idx - IDX_W'(4));
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int N      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level_q,
    output logic [N-1:0] rise_q
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic [STAGES:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[STAGES-1:0], async_in[g]};
        end
        assign level_q[g] = sh[STAGES-1];
        assign rise_q[g]  = sh[STAGES-1] & ~sh[STAGES];
    end
endmodule

// File: rtl/xirq_arb.sv
module xirq_arb #(
    parameter int N  = 5,
    parameter int PW = 3,
    parameter int IW = 3
) (
    input  logic [N-1:0]    cand,
    input  logic [N*PW-1:0] prio_flat,
    output logic            found,
    output logic [IW-1:0]   idx,
    output logic [PW-1:0]   best
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || prio_flat[i*PW +: PW] < best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = prio_flat[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/xirq_isr.sv
module xirq_isr #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  isr_q
);
    logic [N-1:0] set_mask, clr_mask;

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        for (int i = 0; i < N; i++) begin
            if (set_en && set_idx == IW'(i)) set_mask[i] = 1'b1;
            if (clr_en && clr_idx == IW'(i)) clr_mask[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= (isr_q & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int NUM_SRC_P = xirq_pkg::NUM_SRC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC_P-1:0]  irq_in,
    input  logic                  inta,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  int_req,
    output logic [VEC_W-1:0]      vec_out
);
    src_ctrl_t                  ctrl_q [NUM_SRC_P];
    logic [NUM_SRC_P-1:0]       lvl_s, rise_s, edge_lat_q, pend, elig, isr_q, mask_vec;
    logic [NUM_SRC_P*PRIO_W-1:0] prio_flat;
    logic                       req_found, isr_found, grant, eoi_hit;
    logic [IDX_W-1:0]           req_idx, isr_idx;
    logic [PRIO_W-1:0]          req_best, isr_best;
    logic [PRIO_W:0]            ceiling;

    xirq_sync #(.N(NUM_SRC_P), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(irq_in), .level_q(lvl_s), .rise_q(rise_s)
    );

    for (genvar g = 0; g < NUM_SRC_P; g++) begin : g_src
        assign prio_flat[g*PRIO_W +: PRIO_W] = ctrl_q[g].prio;
        assign mask_vec[g] = ctrl_q[g].mask;
        assign pend[g]     = ctrl_q[g].lvl ? lvl_s[g] : edge_lat_q[g];
        assign elig[g]     = pend[g] && !ctrl_q[g].mask && ({1'b0, ctrl_q[g].prio} < ceiling);

        always_ff @(posedge clk) begin
            if (rst)
                edge_lat_q[g] <= 1'b0;
            else if (!ctrl_q[g].lvl && rise_s[g])
                edge_lat_q[g] <= 1'b1;
            else if (grant && req_idx == IDX_W'(g))
                edge_lat_q[g] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)
                ctrl_q[g] <= CTRL_RST;
            else if (reg_we && reg_addr == ADDR_W'(g))
                ctrl_q[g] <= src_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    xirq_arb #(.N(NUM_SRC_P), .PW(PRIO_W), .IW(IDX_W)) u_svc_arb (
        .cand(isr_q), .prio_flat(prio_flat),
        .found(isr_found), .idx(isr_idx), .best(isr_best)
    );

    assign ceiling = isr_found ? {1'b0, isr_best} : {1'b1, {PRIO_W{1'b0}}};

    xirq_arb #(.N(NUM_SRC_P), .PW(PRIO_W), .IW(IDX_W)) u_req_arb (
        .cand(elig), .prio_flat(prio_flat),
        .found(req_found), .idx(req_idx), .best(req_best)
    );

    assign int_req = req_found;
    assign grant   = inta && req_found;
    assign eoi_hit = reg_we && reg_addr == ADDR_W'(EOI_ADDR);

    xirq_isr #(.N(NUM_SRC_P), .IW(IDX_W)) u_isr (
        .clk(clk), .rst(rst),
        .set_en(grant), .set_idx(req_idx),
        .clr_en(eoi_hit && isr_found), .clr_idx(isr_idx),
        .isr_q(isr_q)
    );

    always_ff @(posedge clk) begin
        if (rst)        vec_out <= '0;
        else if (grant) vec_out <= src_vector(req_idx);
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_SRC_P; i++)
            if (reg_addr == ADDR_W'(i))
                reg_rdata[CTRL_W-1:0] = ctrl_q[i];
    end

    logic unused_ok;
    assign unused_ok = ^req_best;
endmodule

// File: rtl/xirq_chk.sv
module xirq_chk
    import xirq_pkg::*;
#(
    parameter int N = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             inta,
    input logic             int_req,
    input logic [VEC_W-1:0] vec_out,
    input logic [N-1:0]     isr_q,
    input logic [N-1:0]     mask_vec,
    input logic [IDX_W-1:0] win_idx,
    input logic             eoi_hit,
    input logic             isr_found
);
    // R1: first cycle out of reset is quiet
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!int_req && vec_out == '0));

    // R3: all sources masked means no request
    p_all_masked_r3: assert property (@(posedge clk) disable iff (rst)
        (&mask_vec) |-> !int_req);

    // R7: acknowledged vector matches the granted source
    p_ack_vector_r7: assert property (@(posedge clk) disable iff (rst)
        (inta && int_req) |=> vec_out == src_vector($past(win_idx)));

    // R7: vector holds without a grant
    p_vec_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(inta && int_req) |=> $stable(vec_out));

    // R8: grant marks the source in service
    p_ack_sets_isr_r8: assert property (@(posedge clk) disable iff (rst)
        (inta && int_req) |=> isr_q[$past(win_idx)]);

    // R8: no in-service bit appears without a grant
    p_no_spurious_isr_r8: assert property (@(posedge clk) disable iff (rst)
        !(inta && int_req) |=> ((isr_q & ~$past(isr_q)) == '0));

    // R10: end-of-interrupt retires exactly one entry
    p_eoi_retires_one_r10: assert property (@(posedge clk) disable iff (rst)
        (eoi_hit && isr_found && !(inta && int_req)) |=>
            ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

bind xirq_ctrl xirq_chk #(.N(NUM_SRC_P)) u_xirq_chk (
    .clk(clk), .rst(rst), .inta(inta), .int_req(int_req), .vec_out(vec_out),
    .isr_q(isr_q), .mask_vec(mask_vec), .win_idx(req_idx),
    .eoi_hit(eoi_hit), .isr_found(isr_found)
);

// File: tb/test_xirq_ctrl.sv
`timescale 1ns/1ps
module test_xirq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  irq_in = '0;
    logic        inta = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        int_req;
    logic [7:0]  vec_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xirq_ctrl i_xirq_ctrl (
        .clk(clk), .rst(rst), .irq_in(irq_in), .inta(inta),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .int_req(int_req), .vec_out(vec_out)
    );

    // ---------------- reference model ----------------
    int m_lvl [5];
    int m_msk [5];
    int m_pri [5];
    bit m_a [5];
    bit m_b [5];
    bit m_c [5];
    bit m_lat [5];
    bit m_svc [5];
    int m_vec;

    function automatic int vec_of(int s);
        return (s == 4) ? 'h11 : ('h0C + s);
    endfunction

    function automatic int m_ceiling();
        int c = 8;
        for (int i = 0; i < 5; i++) if (m_svc[i] && m_pri[i] < c) c = m_pri[i];
        return c;
    endfunction

    function automatic int m_winner();
        int best = -1;
        int bp = 8;
        int ceil_v = m_ceiling();
        for (int i = 0; i < 5; i++) begin
            bit p = (m_lvl[i] != 0) ? m_b[i] : m_lat[i];
            if (p && m_msk[i] == 0 && m_pri[i] < ceil_v && m_pri[i] < bp) begin
                best = i;
                bp = m_pri[i];
            end
        end
        return best;
    endfunction

    function automatic int m_retire();
        int best = -1;
        int bp = 8;
        for (int i = 0; i < 5; i++)
            if (m_svc[i] && m_pri[i] < bp) begin best = i; bp = m_pri[i]; end
        return best;
    endfunction

    function automatic int m_rdata(int a);
        if (a < 5) return m_lvl[a] * 16 + m_msk[a] * 8 + m_pri[a];
        return 0;
    endfunction

    always @(posedge clk) begin
        int w, t;
        bit nl [5];
        bit ns [5];
        if (rst) begin
            for (int i = 0; i < 5; i++) begin
                m_lvl[i] = 0; m_msk[i] = 1; m_pri[i] = 7;
                m_a[i] = 0; m_b[i] = 0; m_c[i] = 0; m_lat[i] = 0; m_svc[i] = 0;
            end
            m_vec = 0;
        end else begin
            w = m_winner();
            t = m_retire();
            nl = m_lat;
            ns = m_svc;
            if (inta && w >= 0) begin
                m_vec = vec_of(w);
                ns[w] = 1;
                nl[w] = 0;
            end
            if (reg_we && reg_addr == 3'd5 && t >= 0) ns[t] = 0;
            for (int i = 0; i < 5; i++)
                if (m_b[i] && !m_c[i] && m_lvl[i] == 0) nl[i] = 1;
            if (reg_we && reg_addr < 3'd5) begin
                m_lvl[reg_addr] = int'(reg_wdata[4]);
                m_msk[reg_addr] = int'(reg_wdata[3]);
                m_pri[reg_addr] = int'(reg_wdata[2:0]);
            end
            m_lat = nl;
            m_svc = ns;
            for (int i = 0; i < 5; i++) begin
                m_c[i] = m_b[i];
                m_b[i] = m_a[i];
                m_a[i] = irq_in[i];
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 R4 R5 R6 R9 R10 int_req vs model", int'(int_req), (m_winner() >= 0) ? 1 : 0);
            chk("R7 vec_out vs model", int'(vec_out), m_vec);
            chk("R2 reg_rdata vs model", int'(reg_rdata), m_rdata(int'(reg_addr)));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(int a, int d);
        reg_addr = 3'(a); reg_wdata = 16'(d); reg_we = 1'b1;
        step(1);
        reg_we = 1'b0;
    endtask

    task automatic ack();
        inta = 1'b1; step(1); inta = 1'b0;
    endtask

    task automatic eoi();
        wr(5, 'hBEEF);
    endtask

    task automatic pulse(int s);
        irq_in[s] = 1'b1; step(2); irq_in[s] = 1'b0;
    endtask

    task automatic rd(int a, int exp, string tag);
        reg_addr = 3'(a); #0.5;
        chk(tag, int'(reg_rdata), exp);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk("R1 int_req after reset", int'(int_req), 0);
        chk("R1 vec_out after reset", int'(vec_out), 0);
        for (int a = 0; a < 5; a++) rd(a, 'h000F, "R1 control reset value");
        for (int a = 5; a < 8; a++) rd(a, 0, "R2 unused address reads zero");

        // R2 reserved bits ignored
        wr(0, 'hFFE2);
        rd(0, 'h0002, "R2 reserved bits dropped");

        // R3 masked edge stays latched
        pulse(1); step(4);
        chk("R3 masked source silent", int'(int_req), 0);
        wr(1, 'h0003);
        chk("R3 latched edge shows after unmask", int'(int_req), 1);
        ack();
        chk("R7 vector int1", int'(vec_out), 'h0D);
        chk("R8 ack clears edge latch", int'(int_req), 0);
        eoi(); step(1);

        // R6 tie, R9 equal priority blocked, R10 retire
        wr(2, 'h0002);
        irq_in[0] = 1'b1; irq_in[2] = 1'b1;
        step(4);
        irq_in[0] = 1'b0; irq_in[2] = 1'b0;
        chk("R6 request pending", int'(int_req), 1);
        ack();
        chk("R6 tie goes to int0", int'(vec_out), 'h0C);
        chk("R9 equal priority blocked", int'(int_req), 0);
        eoi();
        chk("R10 retire unblocks int2", int'(int_req), 1);
        ack();
        chk("R7 vector int2", int'(vec_out), 'h0E);
        eoi(); step(1);

        // R5 level mode
        wr(3, 'h0011);
        irq_in[3] = 1'b1; step(3);
        chk("R5 level request", int'(int_req), 1);
        irq_in[3] = 1'b0; step(3);
        chk("R5 level drop removes request", int'(int_req), 0);
        irq_in[3] = 1'b1; step(3);
        ack();
        chk("R7 vector int3", int'(vec_out), 'h0F);
        chk("R9 source blocks itself", int'(int_req), 0);
        eoi();
        chk("R5 level re-requests after retire", int'(int_req), 1);
        irq_in[3] = 1'b0; step(3);
        chk("R5 level low quiet", int'(int_req), 0);

        // R9 nesting and R10 retire order
        wr(4, 'h0005);
        pulse(4); step(3);
        ack();
        chk("R7 vector int4", int'(vec_out), 'h11);
        pulse(0); step(3);
        chk("R9 more urgent preempts", int'(int_req), 1);
        ack();
        chk("R7 nested vector int0", int'(vec_out), 'h0C);
        pulse(1); step(3);
        chk("R9 less urgent than int0 blocked", int'(int_req), 0);
        eoi();
        chk("R10 retire clears most urgent first", int'(int_req), 1);
        ack();
        chk("R7 vector int1 nested", int'(vec_out), 'h0D);
        eoi(); eoi(); step(2);
        chk("R10 all retired, none pending", int'(int_req), 0);

        // R7 hold with no request
        ack();
        chk("R7 vec_out holds without grant", int'(vec_out), 'h0D);

        // R4 edge latency and stickiness
        wr(2, 'h0001);
        irq_in[2] = 1'b1; step(2);
        chk("R4 not yet visible", int'(int_req), 0);
        step(1);
        chk("R4 visible on third edge", int'(int_req), 1);
        irq_in[2] = 1'b0; step(3);
        chk("R4 held after input falls", int'(int_req), 1);
        wr(2, 'h0009);
        chk("R3 mask withdraws request", int'(int_req), 0);
        wr(2, 'h0001);
        chk("R3 unmask restores request", int'(int_req), 1);
        ack();
        chk("R8 vector int2 after ack", int'(vec_out), 'h0E);
        eoi(); step(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule